// File: doc/BRIEF.md
# Command-Driven Bus Watchdog

This block is a watchdog that a host arms, services and stops through a small register window on a register-mapped slave. Two registers are visible. The control register at word address 0 takes magic command values on write and returns the encoded watchdog state on read. The timeout register at word address 1 holds the expiry period in whole seconds and reads back whatever was last written.

A free-running system tick (`tick_i`, one-cycle pulses) is divided down by `TPS` to a one-second stride that counts the loaded timeout down. When the count runs out, the block spends exactly one cycle in its tripped state. In that cycle it raises a one-cycle reset request toward the board's voltage/reset supervisor, and then it falls back to the disarmed state until it is armed again. An LED output stays lit whenever the watchdog is not actively counting.

Top module: `bus_wdog`

## Requirements
- R1: After reset the state reads 0, `led_o` is 1, `rst_req_o` is 0 and the timeout register (address 1) reads `TMO_INIT`.
- R2: A write of 0x005A to address 0 while the state is 0 moves the state to 1 (armed) on the next clock.
- R3: Once armed with timeout T (T>0), the edge that samples the T*`TPS`-th `tick_i` pulse moves the state to 2 and raises `rst_req_o`, and neither happens before that edge. `rst_req_o` is high for exactly one cycle.
- R4: State 2 lasts one cycle and is followed by state 0. The state then stays 0, with no reset request, however many ticks arrive, until the block is armed again.
- R5: A write of 0x005A while armed reloads the full timeout and restarts the one-second divider, so expiry comes T*`TPS` ticks after the service write.
- R6: A write of 0x00A5 to address 0 returns the state to 0 on the next clock, and no reset request follows.
- R7: Writes of any other value to address 0 leave the state, the countdown and the timeout register unchanged.
- R8: Address 1 is read/write. A new value takes effect at the next arm or service and does not alter a countdown already under way.
- R9: A timeout value of 0 counts as 1 second, that is `TPS` ticks.
- R10: `led_o` is 1 in states 0 and 2 and 0 in state 1.
- R11: A read of address 0 returns the state in bits 1:0 and zeros in all higher bits. The state encoding is 0 = disarmed, 1 = armed and counting, 2 = tripped, and the value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | System tick pulse; `TPS` pulses make one second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write word address (0 control, 1 timeout) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 1 | Read word address |
| rd_data | output | DATA_W | Read data, combinational from `rd_addr` |
| state_o | output | 2 | Encoded watchdog state |
| rst_req_o | output | 1 | One-cycle reset request to the supervisor |
| led_o | output | 1 | Watchdog LED, lit when not armed |

## Verification
The bench sweeps the timeout from 0 to 5 with `TPS`=4 and counts every tick to the expiry edge. A design that is off by one in the divider or in the seconds counter trips one stride early or late, and one that loads 0 literally never trips or wraps around. The service test fires just before expiry. A design that reloads without clearing the divider, or that ignores the service write, trips too soon. Near-miss command values (0x5B, 0xA4, 0x15A) are written mid-countdown and must not shift expiry, and a timeout rewrite during a countdown must not shorten it. After a disarm, long runs of ticks check that no stray reset request ever appears.

// File: rtl/bus_wdog.sv
module bus_wdog #(
  parameter int TPS      = 1000,
  parameter int DATA_W   = 16,
  parameter int TMO_W    = 16,
  parameter int TMO_INIT = 10,
  parameter int PET_CODE = 'h5A,
  parameter int DIS_CODE = 'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        state_o,
  output logic              rst_req_o,
  output logic              led_o
);
  localparam int PRE_W = (TPS > 1) ? $clog2(TPS) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TPS - 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_RUN = 2'd1, S_TRIP = 2'd2;

  logic [1:0]       state_q;
  logic [TMO_W-1:0] tmo_q, cnt_q;
  logic [PRE_W-1:0] pre_q;

  wire ctrl_wr = wr_en && (wr_addr == 1'b0);
  wire pet     = ctrl_wr && (wr_data == DATA_W'(PET_CODE));
  wire stop    = ctrl_wr && (wr_data == DATA_W'(DIS_CODE));
  wire [TMO_W-1:0] load_val = (tmo_q == '0) ? TMO_W'(1) : tmo_q;
  wire sec_end = tick_i && (pre_q == PRE_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tmo_q   <= TMO_W'(TMO_INIT);
      cnt_q   <= '0;
      pre_q   <= '0;
    end else begin
      if (wr_en && wr_addr) tmo_q <= wr_data[TMO_W-1:0];
      case (state_q)
        S_IDLE: if (pet) begin
          state_q <= S_RUN;
          cnt_q   <= load_val;
          pre_q   <= '0;
        end
        S_RUN: begin
          if (stop) state_q <= S_IDLE;
          else if (pet) begin
            cnt_q <= load_val;
            pre_q <= '0;
          end else if (sec_end) begin
            pre_q <= '0;
            if (cnt_q <= TMO_W'(1)) state_q <= S_TRIP;
            else cnt_q <= cnt_q - TMO_W'(1);
          end else if (tick_i) pre_q <= pre_q + PRE_W'(1);
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign state_o   = state_q;
  assign rst_req_o = (state_q == S_TRIP);
  assign led_o     = (state_q != S_RUN);
  assign rd_data   = rd_addr ? DATA_W'(tmo_q) : DATA_W'(state_q);
endmodule

module bus_wdog_chk #(
  parameter int DATA_W   = 16,
  parameter int PET_CODE = 'h5A,
  parameter int DIS_CODE = 'hA5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [1:0]        state_o,
  input logic              rst_req_o,
  input logic              led_o
);
  wire is_pet = wr_en && !wr_addr && (wr_data == DATA_W'(PET_CODE));
  wire is_dis = wr_en && !wr_addr && (wr_data == DATA_W'(DIS_CODE));

  p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && is_pet) |=> state_o == 2'd1);
  p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  p_trip_from_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> $past(state_o) == 2'd1);
  p_trip_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'd2 |=> state_o == 2'd0);
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && !is_pet) |=> state_o == 2'd0);
  p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && is_dis) |=> state_o == 2'd0);
  p_led_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && is_pet) |=> !led_o);
  p_enc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3);
endmodule

bind bus_wdog bus_wdog_chk #(.DATA_W(DATA_W), .PET_CODE(PET_CODE), .DIS_CODE(DIS_CODE)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .state_o(state_o), .rst_req_o(rst_req_o), .led_o(led_o));

// File: tb/test_bus_wdog.sv
module test_bus_wdog;
  localparam int TPS = 4;
  logic clk = 0, rst_n = 0, tick_i = 0, wr_en = 0, wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [1:0] state_o;
  logic rst_req_o, led_o;
  int checks = 0, fails = 0;

  bus_wdog #(.TPS(TPS), .TMO_INIT(7)) i_bus_wdog (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .state_o(state_o),
    .rst_req_o(rst_req_o), .led_o(led_o));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic tick();
    tick_i = 1;
    @(negedge clk);
    tick_i = 0;
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    rd_addr = a; #0.5; v = rd_data;
  endtask

  task automatic st(input int exp, input string tag);
    chk(state_o == 2'(exp), tag, state_o, exp);
  endtask

  task automatic run_ticks(input int n, input int exp_state, input string tag);
    for (int k = 0; k < n; k++) begin
      tick();
      st(exp_state, tag);
      chk(!rst_req_o, tag, rst_req_o, 0);
    end
  endtask

  task automatic expect_trip(input string tag);
    tick();
    st(2, tag);
    chk(rst_req_o, tag, rst_req_o, 1);
    @(negedge clk);
    st(0, "R4 after trip");
    chk(!rst_req_o && led_o, "R4 pulse ended", rst_req_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    st(0, "R1 reset state");
    chk(led_o && !rst_req_o, "R1 led/rst", {led_o, rst_req_o}, 2);
    rd(1, v); chk(v == 7, "R1 timeout init", v, 7);
    rd(0, v); chk(v == 0, "R11 idle readback", v, 0);

    for (int t = 0; t <= 5; t++) begin
      int n;
      n = ((t == 0) ? 1 : t) * TPS;
      wr(1, 16'(t));
      rd(1, v); chk(v == 16'(t), "R8 timeout rw", v, t);
      wr(0, 16'h005A);
      st(1, "R2 arm");
      chk(!led_o, "R10 led off when armed", led_o, 0);
      rd(0, v); chk(v == 1, "R11 run readback", v, 1);
      run_ticks(n - 1, 1, (t == 0) ? "R9 zero timeout" : "R3 early");
      expect_trip((t == 0) ? "R9 trip after TPS" : "R3 trip");
      run_ticks(3 * TPS, 0, "R4 stays idle");
    end

    wr(1, 16'd2);
    wr(0, 16'h005A);
    run_ticks(2 * TPS - 1, 1, "R5 before pet");
    wr(0, 16'h005A);
    st(1, "R5 pet keeps run");
    run_ticks(2 * TPS - 1, 1, "R5 reloaded");
    expect_trip("R5 trip after pet");

    wr(1, 16'd3);
    wr(0, 16'h005A);
    run_ticks(2, 1, "R8 pre");
    wr(1, 16'd1);
    run_ticks(3 * TPS - 3, 1, "R8 no mid change");
    expect_trip("R8 old period kept");
    rd(1, v); chk(v == 1, "R8 new value stored", v, 1);

    wr(0, 16'h005B); wr(0, 16'h00A4); wr(0, 16'h015A); wr(0, 16'h0000);
    st(0, "R7 idle ignores");
    rd(1, v); chk(v == 1, "R7 timeout untouched", v, 1);
    wr(0, 16'h005A);
    run_ticks(2, 1, "R7 pre");
    wr(0, 16'h005B); wr(0, 16'h00A4); wr(0, 16'h015A); wr(0, 16'h01A5);
    st(1, "R7 run ignores");
    run_ticks(1, 1, "R7 count kept");
    expect_trip("R7 expiry unchanged");

    wr(1, 16'd1);
    wr(0, 16'h005A);
    run_ticks(2, 1, "R6 pre");
    wr(0, 16'h00A5);
    st(0, "R6 disarm");
    chk(led_o, "R10 led on after disarm", led_o, 1);
    run_ticks(6 * TPS, 0, "R6 no reset after disarm");
    wr(0, 16'h00A5);
    st(0, "R6 disarm in idle");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule